// File: doc/BRIEF.md
# Basis Sifting Unit for BB84 Key Post-Processing

This block performs the sifting step of BB84 key distillation on a serial stream of photon events. Each qualified event carries the sender's basis and bit and the receiver's basis and bit. The sender side comes either from an on-chip 8-bit pseudo-random generator or from manually driven inputs, chosen by a select pin.

The inputs are registered first. A pipelined compare/store state machine then keeps an event only when both bases agree. For each kept event it writes the sender's bit into a small register-based key memory and counts the kept positions where the two bits disagree. Collection stops when the sifted count reaches a programmed target length. From then on, further events are ignored until a synchronous reset or a start pulse clears the unit.

Downstream logic computes the bit error rate as the error count divided by the sifted count.

Top module: `qkd_sift_unit`

## Requirements
- R1: After synchronous reset, the sifted count, the error count and every key memory bit are 0, and the done flag is low.
- R2: Basis is one bit: 0 is rectilinear and 1 is diagonal. An event whose two bases differ is discarded, and none of the sifted count, the error count or the memory changes.
- R3: For a kept event, the sender's bit is written at the memory address equal to the sifted count before the write. Memory bit i of `key_bits` is address i. The sifted count then rises by exactly 1.
- R4: The error count rises by 1 for each kept event whose sender bit differs from the receiver bit. It never counts discarded events, and it never exceeds the sifted count.
- R5: When the sifted count reaches KEY_LEN (10 by default), `done` goes high in the same cycle. The count never exceeds KEY_LEN, and `done` stays high until cleared.
- R6: While `done` is high, events change neither the memory nor the counts. This includes a kept event already in flight when the target is reached.
- R7: An event sampled with `in_valid` high at clock edge k appears in the sifted count after edge k+2. Events on consecutive cycles are all processed.
- R8: The generator is an 8-bit shift register. It shifts left, and its new bit 0 is the XOR of bits 7, 5, 4 and 3. It loads LFSR_SEED on reset or start and steps once on every cycle with `in_valid` high. The sender basis is its bit 1 and the sender bit is its bit 0, taken before the step. It never holds zero.
- R9: With `manual_sel` high, the sender basis and bit come from `man_basis`/`man_bit`. With it low, they come from the generator, and the manual pins have no effect.
- R10: A cycle with `in_valid` low has no effect on the counts or the memory.
- R11: A `start` pulse clears the counts, memory and done flag, reseeds the generator, and drops any event presented in the same cycle or still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous clear and reseed for a new collection |
| manual_sel | input | 1 | 1: sender values from manual pins, 0: from generator |
| in_valid | input | 1 | Qualifies the event on the data inputs |
| man_basis | input | 1 | Manual sender basis (0 rectilinear, 1 diagonal) |
| man_bit | input | 1 | Manual sender bit |
| rx_basis | input | 1 | Receiver basis |
| rx_bit | input | 1 | Receiver measured bit |
| key_bits | output | KEY_LEN | Sifted key memory, bit i is address i |
| sift_count | output | CNT_W | Number of kept bits |
| err_count | output | CNT_W | Kept bits where sender and receiver disagree |
| done | output | 1 | Target sifted length reached |

## Verification
The hardest case to reach from the ports is a kept event that is still inside the compare stage when the write that completes the target lands. To reach it, the bench fills the memory to one below the target and then presents two matching-basis events on back-to-back cycles. The count must stop at the target, and the second event must not reach the memory or the error count. A second hard case is the generator path. The bench reseeds with a start pulse and fixes the receiver to basis 0 and bit 0, so that the kept positions and errors follow from the shift register sequence alone.

// File: rtl/qks_pkg.sv
package qks_pkg;

    typedef enum logic [1:0] {
        ST_COMPARE = 2'd0,
        ST_STORE   = 2'd1,
        ST_FINISH  = 2'd2
    } sift_state_e;

    typedef struct packed {
        logic valid;
        logic tx_basis;
        logic tx_bit;
        logic rx_basis;
        logic rx_bit;
    } photon_ev_t;

    typedef struct packed {
        logic key_bit;
        logic mismatch;
    } pend_t;

    localparam int unsigned LFSR_W = 8;

    // Fibonacci step for x^8+x^6+x^5+x^4+1
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        return {s[LFSR_W-2:0], fb};
    endfunction

    function automatic logic bases_agree(input photon_ev_t e);
        return e.valid && (e.tx_basis == e.rx_basis);
    endfunction

endpackage

// File: rtl/qks_lfsr.sv
module qks_lfsr
    import qks_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 8'h5B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] next_s;

    always_comb begin
        next_s = lfsr_step(state_q);
        if (next_s == '0) begin
            next_s = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= next_s;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/qks_event_reg.sv
module qks_event_reg
    import qks_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       manual_sel,
    input  logic       in_valid,
    input  logic       man_basis,
    input  logic       man_bit,
    input  logic       gen_basis,
    input  logic       gen_bit,
    input  logic       rx_basis,
    input  logic       rx_bit,
    output photon_ev_t ev
);
    photon_ev_t ev_d;
    photon_ev_t ev_q;

    always_comb begin
        ev_d.valid    = in_valid;
        ev_d.tx_basis = manual_sel ? man_basis : gen_basis;
        ev_d.tx_bit   = manual_sel ? man_bit   : gen_bit;
        ev_d.rx_basis = rx_basis;
        ev_d.rx_bit   = rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign ev = ev_q;
endmodule

// File: rtl/qks_key_store.sv
module qks_key_store #(
    parameter int unsigned DEPTH  = 10,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    output logic [DEPTH-1:0]  bits
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk) begin
            if (clr) begin
                cell_q <= 1'b0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                cell_q <= wdata;
            end
        end
        assign bits[i] = cell_q;
    end
endmodule

// File: rtl/qks_sift_ctrl.sv
module qks_sift_ctrl
    import qks_pkg::*;
#(
    parameter int unsigned KEY_LEN = 10,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  photon_ev_t       ev,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_addr,
    output logic             wr_bit,
    output logic [CNT_W-1:0] sift_count,
    output logic [CNT_W-1:0] err_count,
    output logic             done
);
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(KEY_LEN);

    sift_state_e      state_q, state_d;
    pend_t            pend_q, pend_d;
    logic [CNT_W-1:0] sift_q, sift_d;
    logic [CNT_W-1:0] err_q, err_d;
    logic             keep_now;
    pend_t            pend_new;

    assign keep_now          = bases_agree(ev);
    assign pend_new.key_bit  = ev.tx_bit;
    assign pend_new.mismatch = ev.tx_bit ^ ev.rx_bit;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        sift_d  = sift_q;
        err_d   = err_q;
        unique case (state_q)
            ST_COMPARE: begin
                if (keep_now) begin
                    pend_d  = pend_new;
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                sift_d = sift_q + CNT_W'(1);
                err_d  = err_q + CNT_W'(pend_q.mismatch);
                if (sift_d == TARGET) begin
                    state_d = ST_FINISH;
                    pend_d  = '0;
                end else if (keep_now) begin
                    pend_d  = pend_new;
                    state_d = ST_STORE;
                end else begin
                    state_d = ST_COMPARE;
                end
            end
            ST_FINISH: begin
                state_d = ST_FINISH;
            end
            default: begin
                state_d = ST_COMPARE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= ST_COMPARE;
            pend_q  <= '0;
            sift_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            sift_q  <= sift_d;
            err_q   <= err_d;
        end
    end

    assign wr_en      = (state_q == ST_STORE);
    assign wr_addr    = sift_q;
    assign wr_bit     = pend_q.key_bit;
    assign sift_count = sift_q;
    assign err_count  = err_q;
    assign done       = (state_q == ST_FINISH);
endmodule

// File: rtl/qkd_sift_unit.sv
module qkd_sift_unit
    import qks_pkg::*;
#(
    parameter int unsigned       KEY_LEN   = 10,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5B,
    localparam int unsigned      CNT_W     = $clog2(KEY_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               manual_sel,
    input  logic               in_valid,
    input  logic               man_basis,
    input  logic               man_bit,
    input  logic               rx_basis,
    input  logic               rx_bit,
    output logic [KEY_LEN-1:0] key_bits,
    output logic [CNT_W-1:0]   sift_count,
    output logic [CNT_W-1:0]   err_count,
    output logic               done
);
    logic [LFSR_W-1:0] lfsr_state;
    photon_ev_t        ev_r;
    logic              wr_en;
    logic [CNT_W-1:0]  wr_addr;
    logic              wr_bit;

    qks_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .reload (start),
        .step   (in_valid && !start),
        .state  (lfsr_state)
    );

    qks_event_reg u_evreg (
        .clk        (clk),
        .rst        (rst),
        .flush      (start),
        .manual_sel (manual_sel),
        .in_valid   (in_valid),
        .man_basis  (man_basis),
        .man_bit    (man_bit),
        .gen_basis  (lfsr_state[1]),
        .gen_bit    (lfsr_state[0]),
        .rx_basis   (rx_basis),
        .rx_bit     (rx_bit),
        .ev         (ev_r)
    );

    qks_sift_ctrl #(.KEY_LEN(KEY_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ev         (ev_r),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_bit     (wr_bit),
        .sift_count (sift_count),
        .err_count  (err_count),
        .done       (done)
    );

    qks_key_store #(.DEPTH(KEY_LEN), .ADDR_W(CNT_W)) u_store (
        .clk   (clk),
        .clr   (rst || start),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_bit),
        .bits  (key_bits)
    );
endmodule

// File: rtl/qks_sift_chk.sv
module qks_sift_chk #(
    parameter int unsigned KEY_LEN = 10,
    parameter int unsigned CNT_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [KEY_LEN-1:0] key_bits,
    input logic [CNT_W-1:0]   sift_count,
    input logic [CNT_W-1:0]   err_count,
    input logic               done,
    input logic [7:0]         lfsr_state
);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        sift_count <= CNT_W'(KEY_LEN));

    a_r4_err_le_sift: assert property (@(posedge clk) disable iff (rst)
        err_count <= sift_count);

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((sift_count == $past(sift_count)) ||
                    (sift_count == $past(sift_count) + CNT_W'(1))));

    a_r6_frozen_when_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(key_bits) && $stable(sift_count) && $stable(err_count)));

    a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (sift_count == '0 && err_count == '0 && key_bits == '0 && !done));

    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 8'h00);
endmodule

bind qkd_sift_unit qks_sift_chk #(.KEY_LEN(KEY_LEN), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .key_bits   (key_bits),
    .sift_count (sift_count),
    .err_count  (err_count),
    .done       (done),
    .lfsr_state (lfsr_state)
);

// File: tb/qkd_sift_unit_bench.sv
module qkd_sift_unit_bench;
    localparam int unsigned KEY_LEN = 10;
    localparam int unsigned CNT_W   = 4;
    localparam logic [7:0]  SEED    = 8'h5B;
    localparam time         CLK_PER = 10;

    // {tx_basis, tx_bit, rx_basis, rx_bit, exp_sift[3:0], exp_err[3:0], exp_done}
    localparam int NVEC = 15;
    localparam logic [12:0] VEC [NVEC] = '{
        {4'b0101, 4'd1,  4'd0, 1'b0},
        {4'b0010, 4'd1,  4'd0, 1'b0},
        {4'b1111, 4'd2,  4'd0, 1'b0},
        {4'b1001, 4'd2,  4'd0, 1'b0},
        {4'b1011, 4'd3,  4'd1, 1'b0},
        {4'b0100, 4'd4,  4'd2, 1'b0},
        {4'b0000, 4'd5,  4'd2, 1'b0},
        {4'b1101, 4'd5,  4'd2, 1'b0},
        {4'b1111, 4'd6,  4'd2, 1'b0},
        {4'b0000, 4'd7,  4'd2, 1'b0},
        {4'b1010, 4'd8,  4'd2, 1'b0},
        {4'b0110, 4'd8,  4'd2, 1'b0},
        {4'b0101, 4'd9,  4'd2, 1'b0},
        {4'b1011, 4'd10, 4'd3, 1'b1},
        {4'b0101, 4'd10, 4'd3, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic manual_sel = 1'b1;
    logic in_valid = 1'b0;
    logic man_basis = 1'b0;
    logic man_bit = 1'b0;
    logic rx_basis = 1'b0;
    logic rx_bit = 1'b0;
    logic [KEY_LEN-1:0] key_bits;
    logic [CNT_W-1:0]   sift_count;
    logic [CNT_W-1:0]   err_count;
    logic               done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    qkd_sift_unit #(.KEY_LEN(KEY_LEN), .LFSR_SEED(SEED)) u_qkd_sift_unit (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .manual_sel (manual_sel),
        .in_valid   (in_valid),
        .man_basis  (man_basis),
        .man_bit    (man_bit),
        .rx_basis   (rx_basis),
        .rx_bit     (rx_bit),
        .key_bits   (key_bits),
        .sift_count (sift_count),
        .err_count  (err_count),
        .done       (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic tb_, input logic tk, input logic rb, input logic rk);
        @(negedge clk);
        man_basis = tb_; man_bit = tk; rx_basis = rb; rx_bit = rk;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [7:0] model_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [KEY_LEN-1:0] ekey;
        int ks, ke;
        logic [7:0] lf;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sift after reset", sift_count, 0);
        chk("R1 err after reset", err_count, 0);
        chk("R1 key after reset", key_bits, 0);
        chk("R1 done after reset", done, 0);

        // table walk, manual mode
        manual_sel = 1'b1;
        ekey = '0;
        ks = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            if (v[12] == v[10] && ks < KEY_LEN) begin
                ekey[ks] = v[11];
                ks++;
            end
            send(v[12], v[11], v[10], v[9]);
            chk($sformatf("R2/R3 sift vec %0d", i), sift_count, int'(v[8:5]));
            chk($sformatf("R4 err vec %0d", i), err_count, int'(v[4:1]));
            chk($sformatf("R5/R6 done vec %0d", i), done, int'(v[0]));
        end
        chk("R3 key contents", key_bits, 10'h12B);
        chk("R3 key model", key_bits, ekey);

        // R11: start clears, same-cycle event dropped
        pulse_start();
        chk("R11 sift cleared", sift_count, 0);
        chk("R11 err cleared", err_count, 0);
        chk("R11 key cleared", key_bits, 0);
        chk("R11 done cleared", done, 0);
        @(negedge clk);
        man_basis = 1'b0; man_bit = 1'b1; rx_basis = 1'b0; rx_bit = 1'b1;
        start = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 event with start dropped", sift_count, 0);

        // R10: matching inputs but no valid
        man_basis = 1'b1; man_bit = 1'b1; rx_basis = 1'b1; rx_bit = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 idle sift", sift_count, 0);
        chk("R10 idle err", err_count, 0);
        chk("R10 idle key", key_bits, 0);

        // R7 latency
        man_basis = 1'b0; man_bit = 1'b1; rx_basis = 1'b0; rx_bit = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 after edge k", sift_count, 0);
        @(negedge clk);
        chk("R7 after edge k+1", sift_count, 0);
        @(negedge clk);
        chk("R7 after edge k+2", sift_count, 1);

        // R7 back-to-back events
        man_basis = 1'b1; man_bit = 1'b1; rx_basis = 1'b1; rx_bit = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        man_bit = 1'b0;
        @(negedge clk);
        man_bit = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 back-to-back sift", sift_count, 4);
        chk("R4 back-to-back err", err_count, 1);
        chk("R3 back-to-back key", key_bits[3:0], 4'b1011);

        // fill to target-1 then two in-flight keeps
        for (int i = 0; i < 5; i++) send(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 fill to nine", sift_count, 9);
        @(negedge clk);
        man_basis = 1'b0; man_bit = 1'b1; rx_basis = 1'b0; rx_bit = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 count saturates at target", sift_count, 10);
        chk("R6 in-flight error dropped", err_count, 2);
        chk("R5 done at target", done, 1);
        chk("R6 key last bit", key_bits[9], 1);

        // R8/R9 generator mode
        pulse_start();
        manual_sel = 1'b0;
        lf = SEED;
        ks = 0; ke = 0; ekey = '0;
        for (int i = 0; i < 24; i++) begin
            if (lf[1] == 1'b0 && ks < KEY_LEN) begin
                ekey[ks] = lf[0];
                if (lf[0] != 1'b0) ke++;
                ks++;
            end
            lf = model_step(lf);
            send(1'b1, 1'b1, 1'b0, 1'b0);
        end
        chk("R8/R9 generator sift", sift_count, ks);
        chk("R8/R9 generator err", err_count, ke);
        chk("R8/R9 generator key", key_bits, ekey);
        chk("R8 generator done", done, (ks == KEY_LEN) ? 1 : 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule